// File: doc/BRIEF.md
# Bus Reset and Suspend Self-Reset Recovery

This block handles two ways a USB device can be brought back to a known state. When the line-state logic reports a bus reset, the block clears the 7-bit device address register if the general feature enable is set. It changes no other state. The block also drives the reset condition on a dedicated output pin, and that pin is enabled only when the board-feature enable is set.

Firmware can also request a self reset by writing 1 to a software-reset control bit. If the device is suspended and the power and output controls permit it, the block does not reset at once. It raises an internal wake-up request, which is a purely internal event: no resume signaling is sent on the bus. The request is held until a synchronized clock-running indication shows that clocks are back. The block then issues a device-reset pulse of fixed length. While the request is pending and during the pulse, the software-reset bit reads as 1. If the device is not suspended, the same write starts the reset pulse at once and raises no wake-up request.

Top module: `usbrst_recover`

## Requirements
- R1: With `feat_en`=1, a cycle with `bus_rst_det`=1 leaves `dev_addr` at 0 after the next clock edge, even if `addr_wr` is high in the same cycle.
- R2: With `feat_en`=0, `bus_rst_det` has no effect on `dev_addr`. With no active clearing, `addr_wr`=1 loads `addr_wdata` at the next edge, and otherwise the address holds.
- R3: `rst_pin_oe` is the value of `board_feat_en` registered by one clock. `rst_pin_out` is `bus_rst_det AND board_feat_en` registered by one clock, so the pin is driven 0 and released when the enable is 0.
- R4: A write (`ctl_wr`=1, `ctl_swrst`=1) while `suspended`=1, `susp_pwr_off`=0, `susp_out_en`=0 and `feat_en`=1 gives `wake_req`=1, `sw_rst_bit`=1 and `dev_rst`=0 after the next edge. These values hold for as long as `clk_ok` stays 0.
- R5: A software-reset write while `suspended`=1 with any one of those three control conditions unmet is ignored: `wake_req`, `sw_rst_bit` and `dev_rst` stay 0.
- R6: While a wake-up request is pending, once `clk_ok` has been high for SYNC_STAGES edges, the next edge drops `wake_req` and starts a `dev_rst` pulse of exactly RST_LEN cycles. `sw_rst_bit` stays 1 through the pulse and returns to 0 with it.
- R7: A software-reset write while `suspended`=0 starts the `dev_rst` pulse of RST_LEN cycles at the next edge, with `wake_req` held at 0.
- R8: A write with `ctl_swrst`=0 does nothing. A software-reset write during a pending request or a running pulse does not restart or lengthen it.
- R9: A bus reset has no effect on a pending software-reset request: `wake_req` and `sw_rst_bit` are unchanged.
- R10: After synchronous reset (`rst_n`=0 at an edge), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_det | input | 1 | Bus reset detected by line-state logic |
| suspended | input | 1 | Device is in the suspend state |
| clk_ok | input | 1 | Clocks running indication (asynchronous) |
| feat_en | input | 1 | General feature enable |
| board_feat_en | input | 1 | Board-level feature enable (gates reset pin) |
| susp_pwr_off | input | 1 | Suspend power-off control |
| susp_out_en | input | 1 | Suspend output-enable control |
| addr_wr | input | 1 | Write strobe for the device address |
| addr_wdata | input | ADDR_W | Address write data |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_swrst | input | 1 | Software-reset bit of the control write data |
| dev_addr | output | ADDR_W | Device address register |
| rst_pin_out | output | 1 | Reset indication pin data |
| rst_pin_oe | output | 1 | Reset indication pin output enable |
| sw_rst_bit | output | 1 | Read value of the software-reset bit |
| wake_req | output | 1 | Internal wake-up request (no bus resume) |
| dev_rst | output | 1 | Device reset pulse |

## Verification
The hardest state to reach is a wake-up request that is held across idle cycles and then interrupted by a bus reset before clocks return. Reaching it needs a suspended device, all three control conditions set correctly, and `clk_ok` held low for a controlled time. Directed sequences build this state step by step. They then raise `clk_ok` and count the synchronizer edges to the first cycle of the pulse. A seeded random phase separately drives address writes, bus resets and both feature enables, and checks the address and pin against a bench model every cycle.

// File: rtl/usbrst_pkg.sv
// Package: shared types for the bus reset / suspend self-reset block.
package usbrst_pkg;
    // Software-reset sequencer states.
    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_WAKE  = 2'd1,
        SR_PULSE = 2'd2
    } swrst_state_e;
endpackage

// File: rtl/usbrst_sync.sv
// Module: usbrst_sync
// Brings an asynchronous level into the clk domain through a flop chain.
// Assumes: the input is a slow level; STAGES >= 2.
module usbrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages shift the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/usbrst_addr.sv
// Module: usbrst_addr
// Holds the device address. A bus reset clears it when the feature enable is
// set. The clear wins over a firmware write in the same cycle.
// Assumes: bus_rst_det is already synchronous to clk.
module usbrst_addr #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_det,
    input  logic              feat_en,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] addr_q
);
    logic bus_clear;
    assign bus_clear = bus_rst_det & feat_en;

    // Address register: bus reset clear, firmware load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (bus_clear) addr_q <= '0;
        else if (addr_wr)   addr_q <= addr_wdata;
    end

    AST_ADDR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_det && feat_en) |=> (addr_q == '0)); // R1
    AST_ADDR_NO_FEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_en && !addr_wr) |=> $stable(addr_q)); // R2
endmodule

// File: rtl/usbrst_pin.sv
// Module: usbrst_pin
// Registers the reset indication and its output enable for the board pin.
// The pin is released (enable 0, data 0) when the board feature is off.
// Assumes: the pad logic outside this block does the tri-state.
module usbrst_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_det,
    input  logic board_feat_en,
    output logic pin_out,
    output logic pin_oe
);
    // Pin data and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else begin
            pin_out <= bus_rst_det & board_feat_en;
            pin_oe  <= board_feat_en;
        end
    end

    AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !board_feat_en |=> (!pin_oe && !pin_out)); // R3
endmodule

// File: rtl/usbrst_swrst.sv
// Module: usbrst_swrst
// Software-reset sequencer. A permitted write while suspended raises a wake
// request until clocks are back, then a fixed-length reset pulse is issued.
// A write while not suspended starts the pulse at once.
// Assumes: clk_ok_s has already been synchronized; RST_LEN >= 1.
module usbrst_swrst
    import usbrst_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic suspended,
    input  logic clk_ok_s,
    input  logic feat_en,
    input  logic susp_pwr_off,
    input  logic susp_out_en,
    input  logic ctl_wr,
    input  logic ctl_swrst,
    output logic wake_req,
    output logic dev_rst,
    output logic sw_rst_bit
);
    localparam int CNT_W = $clog2(RST_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_LEN - 1);

    swrst_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic swrst_wr, susp_ok;

    assign swrst_wr = ctl_wr & ctl_swrst;
    assign susp_ok  = suspended & ~susp_pwr_off & ~susp_out_en & feat_en;

    // Next-state and pulse counter decision.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SR_IDLE: begin
                if (swrst_wr && !suspended) begin
                    state_nx = SR_PULSE;
                    cnt_nx   = '0;
                end else if (swrst_wr && susp_ok) begin
                    state_nx = SR_WAKE;
                end
            end
            SR_WAKE: begin
                if (clk_ok_s) begin
                    state_nx = SR_PULSE;
                    cnt_nx   = '0;
                end
            end
            SR_PULSE: begin
                if (cnt == LAST) state_nx = SR_IDLE;
                else             cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = SR_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign wake_req   = (state == SR_WAKE);
    assign dev_rst    = (state == SR_PULSE);
    assign sw_rst_bit = (state != SR_IDLE);

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !clk_ok_s) |=> wake_req); // R4
    AST_SUSP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst_bit && suspended && !susp_ok) |=> !sw_rst_bit); // R5
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |-> (cnt <= LAST)); // R6
    AST_WAKE_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && clk_ok_s) |=> (dev_rst && !wake_req)); // R6
    AST_AWAKE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst_bit && swrst_wr && !suspended) |=> (dev_rst && !wake_req)); // R7
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst && cnt != '0) |-> ($past(dev_rst) && cnt == $past(cnt) + 1'b1)); // R8
endmodule

// File: rtl/usbrst_recover.sv
// Module: usbrst_recover (top)
// Bus reset reaction and the suspend-time software-reset recovery.
// Assumes: bus_rst_det and the control bits are synchronous to clk. clk_ok
// may be asynchronous and is synchronized here.
module usbrst_recover #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int RST_LEN     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_det,
    input  logic              suspended,
    input  logic              clk_ok,
    input  logic              feat_en,
    input  logic              board_feat_en,
    input  logic              susp_pwr_off,
    input  logic              susp_out_en,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              ctl_wr,
    input  logic              ctl_swrst,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              rst_pin_out,
    output logic              rst_pin_oe,
    output logic              sw_rst_bit,
    output logic              wake_req,
    output logic              dev_rst
);
    logic clk_ok_s;

    usbrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(clk_ok), .q_sync(clk_ok_s)
    );

    usbrst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .bus_rst_det(bus_rst_det), .feat_en(feat_en),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .addr_q(dev_addr)
    );

    usbrst_pin u_pin (
        .clk(clk), .rst_n(rst_n), .bus_rst_det(bus_rst_det),
        .board_feat_en(board_feat_en), .pin_out(rst_pin_out), .pin_oe(rst_pin_oe)
    );

    usbrst_swrst #(.RST_LEN(RST_LEN)) u_swrst (
        .clk(clk), .rst_n(rst_n), .suspended(suspended), .clk_ok_s(clk_ok_s),
        .feat_en(feat_en), .susp_pwr_off(susp_pwr_off), .susp_out_en(susp_out_en),
        .ctl_wr(ctl_wr), .ctl_swrst(ctl_swrst), .wake_req(wake_req),
        .dev_rst(dev_rst), .sw_rst_bit(sw_rst_bit)
    );

    AST_BUSRST_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && bus_rst_det && !clk_ok_s) |=> (wake_req && sw_rst_bit)); // R9
    AST_PIN_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        board_feat_en |=> rst_pin_oe); // R3
endmodule

// File: tb/usbrst_recover_bench.sv
module usbrst_recover_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;
    localparam int SYNC = 2;
    localparam int RLEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_det = 0, suspended = 0, clk_ok = 0, feat_en = 0, board_feat_en = 0;
    logic susp_pwr_off = 0, susp_out_en = 0, addr_wr = 0, ctl_wr = 0, ctl_swrst = 0;
    logic [AW-1:0] addr_wdata = '0;
    logic [AW-1:0] dev_addr;
    logic rst_pin_out, rst_pin_oe, sw_rst_bit, wake_req, dev_rst;

    int n_tests = 0, n_fail = 0;
    logic [AW-1:0] exp_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbrst_recover #(.ADDR_W(AW), .SYNC_STAGES(SYNC), .RST_LEN(RLEN)) u_usbrst_recover (
        .clk(clk), .rst_n(rst_n), .bus_rst_det(bus_rst_det), .suspended(suspended),
        .clk_ok(clk_ok), .feat_en(feat_en), .board_feat_en(board_feat_en),
        .susp_pwr_off(susp_pwr_off), .susp_out_en(susp_out_en), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .ctl_wr(ctl_wr), .ctl_swrst(ctl_swrst),
        .dev_addr(dev_addr), .rst_pin_out(rst_pin_out), .rst_pin_oe(rst_pin_oe),
        .sw_rst_bit(sw_rst_bit), .wake_req(wake_req), .dev_rst(dev_rst)
    );

    // Reference address model.
    function automatic logic [AW-1:0] next_addr(logic [AW-1:0] cur, logic fe,
                                                logic br, logic wr, logic [AW-1:0] wd);
        if (fe && br) return '0;
        if (wr)       return wd;
        return cur;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one clock edge, then settle.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Check the software-reset outputs {wake_req, dev_rst, sw_rst_bit}.
    task automatic chk_sr(string req, logic w, logic d, logic b);
        chk(req, {29'd0, wake_req, dev_rst, sw_rst_bit}, {29'd0, w, d, b});
    endtask

    task automatic swrst_write();
        ctl_wr = 1; ctl_swrst = 1;
        step();
        ctl_wr = 0; ctl_swrst = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic fe, br, wr, be;
        logic [AW-1:0] wd;
        void'($urandom(32'd4242));
        #1;
        step(); step();
        // R10: reset state
        chk("R10 addr", dev_addr, 0);
        chk("R10 pin", {rst_pin_out, rst_pin_oe}, 0);
        chk_sr("R10 swrst", 0, 0, 0);
        rst_n = 1;

        // R1 directed: clear wins over a write in the same cycle
        addr_wr = 1; addr_wdata = 7'h55; step(); exp_addr = 7'h55;
        chk("R2 load", dev_addr, exp_addr);
        feat_en = 1; bus_rst_det = 1; addr_wdata = 7'h2A; step(); exp_addr = 0;
        chk("R1 clear beats write", dev_addr, 0);
        addr_wr = 0; bus_rst_det = 0; feat_en = 0;

        // Random phase: R1 R2 R3
        for (int i = 0; i < 400; i++) begin
            fe = 1'($urandom); br = ($urandom % 4) == 0; wr = 1'($urandom);
            be = 1'($urandom); wd = AW'($urandom);
            feat_en = fe; bus_rst_det = br; addr_wr = wr; addr_wdata = wd;
            board_feat_en = be;
            step();
            exp_addr = next_addr(exp_addr, fe, br, wr, wd);
            chk(fe && br ? "R1 addr" : "R2 addr", dev_addr, exp_addr);
            chk("R3 oe", rst_pin_oe, be);
            chk("R3 out", rst_pin_out, br & be);
        end
        bus_rst_det = 0; addr_wr = 0; board_feat_en = 0; feat_en = 1;
        step();
        chk_sr("R9 random phase left no sw reset", 0, 0, 0);

        // R5: each blocking condition
        suspended = 1;
        susp_pwr_off = 1; swrst_write(); step(); chk_sr("R5 pwr_off", 0, 0, 0);
        susp_pwr_off = 0; susp_out_en = 1; swrst_write(); step(); chk_sr("R5 out_en", 0, 0, 0);
        susp_out_en = 0; feat_en = 0; swrst_write(); step(); chk_sr("R5 feat", 0, 0, 0);
        feat_en = 1;

        // R8: write with bit 0 ignored
        ctl_wr = 1; ctl_swrst = 0; step(); ctl_wr = 0;
        chk_sr("R8 zero write", 0, 0, 0);

        // R4: permitted write while suspended
        swrst_write();
        chk_sr("R4 wake", 1, 0, 1);
        for (int i = 0; i < 5; i++) begin
            step(); chk_sr("R4 held", 1, 0, 1);
        end
        // R9: bus reset while pending
        addr_wr = 1; addr_wdata = 7'h11; step(); addr_wr = 0;
        bus_rst_det = 1; step(); bus_rst_det = 0;
        chk("R9 addr cleared", dev_addr, 0);
        chk_sr("R9 request kept", 1, 0, 1);
        // R8: repeat write while pending
        swrst_write(); chk_sr("R8 pending rewrite", 1, 0, 1);

        // R6: clocks return
        clk_ok = 1;
        for (int i = 0; i < SYNC; i++) begin
            step(); chk_sr("R6 sync wait", 1, 0, 1);
        end
        step(); chk_sr("R6 pulse start", 0, 1, 1);
        for (int i = 1; i < RLEN; i++) begin
            if (i == 1) begin
                swrst_write(); // R8 rewrite during pulse
            end else begin
                step();
            end
            chk_sr("R6 pulse", 0, 1, 1);
        end
        step(); chk_sr("R6 pulse end", 0, 0, 0);
        step(); chk_sr("R8 no restart", 0, 0, 0);

        // R6: clk_ok already high at the write
        swrst_write(); chk_sr("R6 wake fast", 1, 0, 1);
        step(); chk_sr("R6 fast pulse", 0, 1, 1);
        for (int i = 1; i < RLEN; i++) step();
        step(); chk_sr("R6 fast end", 0, 0, 0);

        // R7: not suspended, immediate pulse
        suspended = 0; clk_ok = 0; susp_pwr_off = 1;
        swrst_write(); chk_sr("R7 immediate", 0, 1, 1);
        for (int i = 1; i < RLEN; i++) begin
            step(); chk_sr("R7 pulse", 0, 1, 1);
        end
        step(); chk_sr("R7 end", 0, 0, 0);

        // R10: reset mid-request
        suspended = 1; susp_pwr_off = 0; swrst_write();
        rst_n = 0; step(); rst_n = 1;
        chk_sr("R10 reset clears request", 0, 0, 0);
        chk("R10 addr", dev_addr, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule